// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller Core

This block is the per-processor heart of a vectored interrupt controller. It keeps three bit arrays with one bit per vector (pending requests, vectors in service, and the trigger kind of each request) and derives a processor priority from a software task priority and the most important vector now being serviced. From these it decides whether a request may interrupt the processor. It raises an interrupt line when one may, and on request it hands over the best eligible vector.

Requests arrive on a set port that carries a vector and a level/edge flag. The processor takes an interrupt with a one-cycle acknowledge strobe. One cycle later the result comes back: a real vector, the spurious vector when every pending request is held back by priority, or a "none" indication. The processor ends service with an end-of-interrupt strobe. That strobe retires the most important in-service vector and, for level-triggered vectors, announces the retired vector on a broadcast output so that upstream sources can re-sample their lines. Register decode, timers and destination routing live elsewhere.

Top module: `prio_vector_ctrl`

## Requirements
- R1: After reset the task priority is 0, the spurious-control register holds 0x0FF (controller disabled), and all three arrays are empty. `irq_out` is low and an acknowledge returns "none".
- R2: A set request makes its vector pending and records its trigger kind: `set_level`=1 marks it level, 0 marks it edge. A later request for the same vector overwrites the kind.
- R3: Among pending vectors, the one with the highest number is the candidate. Among in-service vectors, the one with the highest number is the active one.
- R4: Priority class means bits 7:4 of a vector. The in-service class is the active in-service vector's class, or 0 when nothing is in service. Processor priority is the task priority when task-priority bits 7:4 are at least the in-service class. Otherwise it is the in-service class placed in bits 7:4 with bits 3:0 zero.
- R5: The candidate is blocked when processor priority is nonzero and the candidate's class is less than or equal to bits 7:4 of processor priority. An acknowledge while blocked returns the spurious vector, which is spurious-control bits 7:0, with `ack_none`=0. It changes no array.
- R6: When an acknowledge is accepted, `ack_valid` is high for exactly the following cycle. For an unblocked candidate, the vector moves from pending to in service and is returned on `ack_vec`. `ack_vec` is 0 whenever nothing is returned.
- R7: Spurious-control bit 8 is the enable. While it is 0, `irq_out` stays low and an acknowledge returns `ack_none`=1 whatever is pending.
- R8: An end-of-interrupt strobe gives `eoi_done` for exactly the following cycle and clears the active in-service vector. If that vector is level-triggered and spurious-control bit 12 is 0, `eoi_bcast_valid` pulses in the same cycle as `eoi_done`, with the vector on `eoi_bcast_vec`. Otherwise the broadcast stays low, and `eoi_bcast_vec` is 0 when no broadcast is made.
- R9: With spurious-control bit 12 set, a level-triggered vector retires without any broadcast.
- R10: `irq_out` is a function of registered state only. It is high exactly when the controller is enabled and an unblocked candidate exists, and it follows every state change in the cycle after the strobe that caused it.
- R11: A spurious-control write keeps bits 12 and 8:0 of `svr_data`. Bits 15:13 and 11:9 have no effect. A task-priority write stores all 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| set_valid | input | 1 | Request strobe |
| set_vec | input | 8 | Vector to make pending |
| set_level | input | 1 | 1 = level-triggered, 0 = edge |
| ack_req | input | 1 | Acknowledge strobe from the processor |
| ack_valid | output | 1 | Acknowledge result valid |
| ack_none | output | 1 | No vector to deliver |
| ack_vec | output | 8 | Delivered or spurious vector |
| eoi_req | input | 1 | End-of-interrupt strobe |
| eoi_done | output | 1 | End-of-interrupt completed |
| tpr_wr | input | 1 | Task-priority write strobe |
| tpr_data | input | 8 | Task-priority value |
| svr_wr | input | 1 | Spurious-control write strobe |
| svr_data | input | 16 | Spurious-control value |
| irq_out | output | 1 | Interrupt request to the processor |
| eoi_bcast_valid | output | 1 | Level-vector retirement broadcast |
| eoi_bcast_vec | output | 8 | Retired level vector |

## Verification
A pending, in-service or trigger bit that is wrong inside the controller shows at the ports in one of two ways. `irq_out` changes within one cycle of the strobe that corrupted it, or the wrong vector appears on the next acknowledge or broadcast. Comparing `irq_out` and every result output each cycle against a behavioural model therefore catches a bad array bit no later than the next acknowledge or end-of-interrupt that involves it. Directed sequences walk the priority arithmetic through its edge values: equal classes, a nonzero task priority with class 0, and an empty in-service array. A long random phase then mixes coincident set, acknowledge and end-of-interrupt strobes.

// File: rtl/pvc_pkg.sv
package pvc_pkg;
   localparam int SVR_IN_W     = 16;
   localparam int SVR_EN_BIT   = 8;
   localparam int SVR_QUIET_BIT = 12;
   localparam int CLASS_W      = 4;

   typedef enum logic [1:0] {
      RES_NONE  = 2'd0,
      RES_SPUR  = 2'd1,
      RES_TAKEN = 2'd2
   } ack_res_e;
endpackage

// File: rtl/pvc_msb_find.sv
module pvc_msb_find #(
   parameter int N   = 256,
   parameter int SEG = 16,
   localparam int IW  = $clog2(N),
   localparam int SW  = $clog2(SEG),
   localparam int NSEG = N / SEG,
   localparam int GW  = (NSEG > 1) ? $clog2(NSEG) : 1
) (
   input  logic [N-1:0]  bits,
   output logic          found,
   output logic [IW-1:0] idx
);
   if (N % SEG != 0 || (1 << IW) != N) begin : g_bad_cfg
      $error("pvc_msb_find: N must be a power of two and a multiple of SEG");
   end

   logic [NSEG-1:0]  seg_any;
   logic [SW-1:0]    seg_idx [NSEG];

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      always_comb begin
         seg_any[g] = |bits[g*SEG +: SEG];
         seg_idx[g] = '0;
         for (int b = 0; b < SEG; b++) begin
            if (bits[g*SEG + b]) seg_idx[g] = SW'(b);
         end
      end
   end

   logic [GW-1:0] top_g;
   always_comb begin
      top_g = '0;
      for (int g = 0; g < NSEG; g++) begin
         if (seg_any[g]) top_g = GW'(g);
      end
      found = |seg_any;
      idx   = IW'({top_g, seg_idx[top_g]});
   end
endmodule

// File: rtl/pvc_prio_gate.sv
module pvc_prio_gate #(
   parameter int VW = 8,
   localparam int CW = pvc_pkg::CLASS_W
) (
   input  logic [VW-1:0] tpr,
   input  logic          isr_found,
   input  logic [VW-1:0] isr_top,
   input  logic          irr_found,
   input  logic [VW-1:0] irr_top,
   output logic [VW-1:0] ppr,
   output logic          blocked
);
   if (VW <= CW) begin : g_bad_vw
      $error("pvc_prio_gate: vector width must exceed class width");
   end

   logic [CW-1:0] svc_class;
   always_comb begin
      svc_class = isr_found ? isr_top[VW-1 -: CW] : '0;
      if (tpr[VW-1 -: CW] >= svc_class) ppr = tpr;
      else                              ppr = {svc_class, {(VW-CW){1'b0}}};
      blocked = irr_found && (ppr != '0) &&
                (irr_top[VW-1 -: CW] <= ppr[VW-1 -: CW]);
   end
endmodule

// File: rtl/prio_vector_ctrl.sv
module prio_vector_ctrl #(
   parameter int NVEC = 256,
   parameter int SEG  = 16,
   localparam int VW  = $clog2(NVEC),
   localparam int SVW = pvc_pkg::SVR_IN_W
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          set_valid,
   input  logic [VW-1:0] set_vec,
   input  logic          set_level,
   input  logic          ack_req,
   output logic          ack_valid,
   output logic          ack_none,
   output logic [VW-1:0] ack_vec,
   input  logic          eoi_req,
   output logic          eoi_done,
   input  logic          tpr_wr,
   input  logic [VW-1:0] tpr_data,
   input  logic          svr_wr,
   input  logic [SVW-1:0] svr_data,
   output logic          irq_out,
   output logic          eoi_bcast_valid,
   output logic [VW-1:0] eoi_bcast_vec
);
   import pvc_pkg::*;

   if ((1 << VW) != NVEC || VW > SVR_EN_BIT) begin : g_bad_nvec
      $error("prio_vector_ctrl: NVEC must be a power of two up to 256");
   end

   logic [NVEC-1:0] irr_q, isr_q, tmr_q;
   logic [NVEC-1:0] irr_n, isr_n, tmr_n;
   logic [VW-1:0]   tpr_q, spur_q;
   logic            en_q, quiet_q;

   logic            irr_f, isr_f, blocked;
   logic [VW-1:0]   irr_i, isr_i, ppr;
   ack_res_e        res;

   pvc_msb_find #(.N(NVEC), .SEG(SEG)) u_irr_find (
      .bits(irr_q), .found(irr_f), .idx(irr_i));
   pvc_msb_find #(.N(NVEC), .SEG(SEG)) u_isr_find (
      .bits(isr_q), .found(isr_f), .idx(isr_i));

   pvc_prio_gate #(.VW(VW)) u_gate (
      .tpr(tpr_q), .isr_found(isr_f), .isr_top(isr_i),
      .irr_found(irr_f), .irr_top(irr_i), .ppr(ppr), .blocked(blocked));

   always_comb begin
      if (!en_q || !irr_f) res = RES_NONE;
      else if (blocked)    res = RES_SPUR;
      else                 res = RES_TAKEN;
   end

   assign irq_out = (res == RES_TAKEN);

   always_comb begin
      irr_n = irr_q;
      isr_n = isr_q;
      tmr_n = tmr_q;
      if (eoi_req && isr_f)               isr_n[isr_i] = 1'b0;
      if (ack_req && res == RES_TAKEN) begin
         irr_n[irr_i] = 1'b0;
         isr_n[irr_i] = 1'b1;
      end
      if (set_valid) begin
         irr_n[set_vec] = 1'b1;
         tmr_n[set_vec] = set_level;
      end
   end

   logic bcast_now;
   assign bcast_now = eoi_req && isr_f && tmr_q[isr_i] && !quiet_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q           <= '0;
         isr_q           <= '0;
         tmr_q           <= '0;
         tpr_q           <= '0;
         spur_q          <= '1;
         en_q            <= 1'b0;
         quiet_q         <= 1'b0;
         ack_valid       <= 1'b0;
         ack_none        <= 1'b0;
         ack_vec         <= '0;
         eoi_done        <= 1'b0;
         eoi_bcast_valid <= 1'b0;
         eoi_bcast_vec   <= '0;
      end else begin
         irr_q <= irr_n;
         isr_q <= isr_n;
         tmr_q <= tmr_n;
         if (tpr_wr) tpr_q <= tpr_data;
         if (svr_wr) begin
            en_q    <= svr_data[SVR_EN_BIT];
            quiet_q <= svr_data[SVR_QUIET_BIT];
            spur_q  <= svr_data[VW-1:0];
         end
         ack_valid <= ack_req;
         ack_none  <= ack_req && (res == RES_NONE);
         if (!ack_req)              ack_vec <= '0;
         else if (res == RES_TAKEN) ack_vec <= irr_i;
         else if (res == RES_SPUR)  ack_vec <= spur_q;
         else                       ack_vec <= '0;
         eoi_done        <= eoi_req;
         eoi_bcast_valid <= bcast_now;
         eoi_bcast_vec   <= bcast_now ? isr_i : '0;
      end
   end

   // R6: a result appears only in the cycle after an acknowledge strobe
   assert_ack_follows_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ack_valid |-> $past(ack_req));

   // R6: a delivered vector is in service when it is reported
   assert_taken_in_service_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && !ack_none && $past(res == RES_TAKEN)) |-> isr_q[ack_vec]);

   // R7: the interrupt line never rises while disabled or with nothing pending
   assert_irq_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> (en_q && irr_q != '0));

   // R8: completion pulse tracks the strobe one cycle later
   assert_eoi_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(eoi_req) |-> eoi_done);

   // R9: a broadcast implies the suppression bit was clear and an EOI occurred
   assert_bcast_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      eoi_bcast_valid |-> ($past(eoi_req) && !$past(quiet_q) && eoi_done));
endmodule

// File: tb/sim_prio_vector_ctrl.sv
module sim_prio_vector_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic       set_valid = 0, set_level = 0, ack_req = 0, eoi_req = 0;
   logic       tpr_wr = 0, svr_wr = 0;
   logic [7:0] set_vec = 0, tpr_data = 0;
   logic [15:0] svr_data = 0;
   logic       ack_valid, ack_none, eoi_done, irq_out, eoi_bcast_valid;
   logic [7:0] ack_vec, eoi_bcast_vec;

   prio_vector_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_vec(set_vec),
      .set_level(set_level), .ack_req(ack_req), .ack_valid(ack_valid),
      .ack_none(ack_none), .ack_vec(ack_vec), .eoi_req(eoi_req),
      .eoi_done(eoi_done), .tpr_wr(tpr_wr), .tpr_data(tpr_data),
      .svr_wr(svr_wr), .svr_data(svr_data), .irq_out(irq_out),
      .eoi_bcast_valid(eoi_bcast_valid), .eoi_bcast_vec(eoi_bcast_vec));

   int nvec = 0, nbad = 0;
   bit finished = 0;

   // behavioural reference
   bit [255:0] m_irr, m_isr, m_tmr;
   int m_tpr = 0, m_spur = 255;
   bit m_en = 0, m_quiet = 0;

   function automatic int top_of(bit [255:0] a);
      for (int i = 255; i >= 0; i--) if (a[i]) return i;
      return -1;
   endfunction

   function automatic int prio_now();
      int c = (top_of(m_isr) < 0) ? 0 : top_of(m_isr) / 16;
      return ((m_tpr / 16) >= c) ? m_tpr : c * 16;
   endfunction

   function automatic bit held_back();
      int p = prio_now();
      int r = top_of(m_irr);
      return (r >= 0) && (p != 0) && ((r / 16) <= (p / 16));
   endfunction

   function automatic bit can_take();
      return m_en && top_of(m_irr) >= 0 && !held_back();
   endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nvec++;
      if (!ok) begin
         nbad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic step();
      int r, s, e_vec, b_vec;
      bit take, e_none, bc;
      @(posedge clk);
      #1;
      r = top_of(m_irr);
      s = top_of(m_isr);
      take = can_take();
      e_none = !(m_en && r >= 0);
      e_vec = !ack_req ? 0 : take ? r : (!e_none ? m_spur : 0);
      bc = eoi_req && s >= 0 && m_tmr[s] && !m_quiet;
      b_vec = bc ? s : 0;
      if (eoi_req && s >= 0) m_isr[s] = 0;
      if (ack_req && take) begin m_irr[r] = 0; m_isr[r] = 1; end
      if (set_valid) begin m_irr[set_vec] = 1; m_tmr[set_vec] = set_level; end
      if (tpr_wr) m_tpr = tpr_data;
      if (svr_wr) begin
         m_en = svr_data[8]; m_quiet = svr_data[12]; m_spur = svr_data[7:0];
      end
      chk(ack_valid == ack_req, "R6 ack_valid", ack_valid, ack_req);
      chk(ack_none == (ack_req && e_none), "R7 ack_none", ack_none, ack_req && e_none);
      chk(ack_vec == e_vec[7:0], "R6 ack_vec", ack_vec, e_vec);
      chk(eoi_done == eoi_req, "R8 eoi_done", eoi_done, eoi_req);
      chk(eoi_bcast_valid == bc, "R8 bcast_valid", eoi_bcast_valid, bc);
      chk(eoi_bcast_vec == b_vec[7:0], "R8 bcast_vec", eoi_bcast_vec, b_vec);
      chk(irq_out == can_take(), "R10 irq_out", irq_out, can_take());
      set_valid = 0; ack_req = 0; eoi_req = 0; tpr_wr = 0; svr_wr = 0;
   endtask

   task automatic do_set(input int v, input bit lvl);
      set_valid = 1; set_vec = v[7:0]; set_level = lvl; step();
   endtask
   task automatic do_ack();  ack_req = 1; step(); endtask
   task automatic do_eoi();  eoi_req = 1; step(); endtask
   task automatic do_tpr(input int d); tpr_wr = 1; tpr_data = d[7:0]; step(); endtask
   task automatic do_svr(input int d); svr_wr = 1; svr_data = d[15:0]; step(); endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         nbad++;
         $display("FAIL watchdog actual=running expected=done");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R1: reset state
      chk(irq_out == 0, "R1 irq after reset", irq_out, 0);
      do_ack();
      chk(ack_none == 1, "R1 ack none after reset", ack_none, 1);
      // R7: disabled controller ignores pending request
      do_set(8'h30, 0);
      chk(irq_out == 0, "R7 irq while disabled", irq_out, 0);
      do_ack();
      chk(ack_none == 1 && ack_vec == 0, "R7 ack while disabled", ack_vec, 0);
      // R11: only bits 12 and 8:0 kept; here enable=1, quiet=0, spurious=A7
      do_svr(16'hE3A7);
      chk(irq_out == 1, "R10 irq on enable", irq_out, 1);
      // R3: highest-numbered pending wins
      do_set(8'h45, 0);
      do_set(8'h91, 1);
      do_ack();
      chk(ack_vec == 8'h91 && !ack_none, "R3 highest vector", ack_vec, 8'h91);
      // R5: pending classes 4 and 3 blocked by in-service class 9
      chk(irq_out == 0, "R5 irq blocked", irq_out, 0);
      do_ack();
      chk(ack_vec == 8'hA7 && !ack_none, "R5 R11 spurious vector", ack_vec, 8'hA7);
      do_set(8'hA2, 0);
      chk(irq_out == 1, "R4 higher class passes", irq_out, 1);
      do_ack();
      chk(ack_vec == 8'hA2, "R6 take A2", ack_vec, 8'hA2);
      // R8: edge vector retires silently
      do_eoi();
      chk(eoi_done == 1 && eoi_bcast_valid == 0, "R8 edge no broadcast", eoi_bcast_valid, 0);
      // R2 R8: level vector broadcast
      do_eoi();
      chk(eoi_bcast_valid == 1 && eoi_bcast_vec == 8'h91, "R2 level broadcast", eoi_bcast_vec, 8'h91);
      chk(irq_out == 1, "R10 irq after retire", irq_out, 1);
      // R4: task priority 0x50 blocks class 4
      do_tpr(8'h50);
      chk(irq_out == 0, "R4 tpr blocks equal-or-lower", irq_out, 0);
      do_tpr(8'h3F);
      do_ack();
      chk(ack_vec == 8'h45, "R4 tpr 3F passes class 4", ack_vec, 8'h45);
      // R9: quiet bit set, spurious C8
      do_svr(16'h11C8);
      do_tpr(8'h00);
      do_set(8'h77, 1);
      do_ack();
      chk(ack_vec == 8'h77, "R9 take 77", ack_vec, 8'h77);
      do_eoi();
      chk(eoi_done == 1 && eoi_bcast_valid == 0, "R9 level suppressed", eoi_bcast_valid, 0);
      // R4: tpr 05 with class-4 in service gives 0x40, 0x30 blocked
      do_tpr(8'h05);
      do_ack();
      chk(ack_vec == 8'hC8, "R4 in-service class dominates", ack_vec, 8'hC8);
      do_eoi();
      chk(irq_out == 1, "R4 tpr 05 passes class 3", irq_out, 1);
      do_ack();
      chk(ack_vec == 8'h30, "R6 take 30", ack_vec, 8'h30);
      do_eoi();
      // R4: nonzero tpr low nibble blocks class 0
      do_set(8'h0A, 0);
      do_ack();
      chk(ack_vec == 8'hC8, "R4 class 0 vs tpr 05", ack_vec, 8'hC8);
      do_eoi();
      chk(eoi_done == 1 && eoi_bcast_valid == 0, "R8 empty eoi", eoi_bcast_valid, 0);
      // R2: same vector re-requested as edge overwrites level kind
      do_tpr(8'h00);
      do_set(8'h0A, 1);
      do_set(8'h0A, 0);
      do_svr(16'h0100);
      do_ack();
      do_eoi();
      chk(eoi_bcast_valid == 0, "R2 kind overwritten", eoi_bcast_valid, 0);
      // random phase, compared against the model every cycle
      for (int n = 0; n < 4000; n++) begin
         int k = $urandom_range(0, 99);
         if (k < 35) begin
            set_valid = 1; set_vec = 8'($urandom); set_level = 1'($urandom);
         end
         if (k >= 20 && k < 50) ack_req = 1;
         if (k >= 45 && k < 70) eoi_req = 1;
         if (k >= 70 && k < 74) begin tpr_wr = 1; tpr_data = 8'($urandom); end
         if (k >= 74 && k < 76) begin
            svr_wr = 1; svr_data = 16'($urandom) | ((k == 74) ? 16'h0100 : 16'h0);
         end
         step();
      end
      finished = 1;
      summary();
      $finish;
   end
endmodule